// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter built from 4-bit slices. Each slice updates all of its bits together on the rising clock edge. It can be loaded in parallel from a data input, can hold its value, or can step up or down by one. All controls are active low except the direction select. A slice advances only when both of its enables are low. Each slice produces an active-low carry that marks its terminal value in the current direction. That carry feeds the next slice's chain enable, so the slices form one wide synchronous counter with no extra gating.

The top module chains a parameterized number of slices. The shared count enable, load and direction go to every slice. The external chain enable goes to the lowest slice only. The last slice's carry becomes the block's carry output, and a following block can chain from it in the same way. A synchronous active-low reset clears every slice to zero.

Top module: `updn_chain`

## Requirements
- R1: When `rst_n` is low at a rising edge, `q` becomes all zeros after that edge, whatever the other inputs are.
- R2: With `rst_n` high and `load_n` low at a rising edge, `q` takes the value of `din` after that edge. This happens whatever the levels of `cnt_en_n`, `chain_en_n` and `up_dn`.
- R3: With `rst_n` and `load_n` high, `q` keeps its value across a rising edge if `cnt_en_n` or `chain_en_n` is high.
- R4: With `rst_n` and `load_n` high, both enables low and `up_dn` high (1 = up), `q` rises by one at each rising edge, and all ones wraps to all zeros.
- R5: Under the same conditions with `up_dn` low (0 = down), `q` falls by one at each rising edge, and all zeros wraps to all ones.
- R6: `carry_n` is combinational. It is low exactly when `chain_en_n` is low and `q` is at its terminal value: all ones when `up_dn` is 1, all zeros when `up_dn` is 0.
- R7: Across slice boundaries the chain counts as one binary number of `STAGES*4` bits. A higher slice steps only on the edge where every lower slice is at its terminal value, so 0x0F steps up to 0x10 and 0x10 steps down to 0x0F.
- R8: Changes on `load_n`, `cnt_en_n`, `chain_en_n`, `up_dn` or `din` between rising edges leave `q` unchanged. Only their levels at the edge matter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every slice updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the count |
| load_n | input | 1 | Synchronous parallel load, active low; overrides counting |
| cnt_en_n | input | 1 | Count enable shared by all slices, active low |
| chain_en_n | input | 1 | Chain enable into the lowest slice, active low; also gates the carry |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | STAGES*4 | Parallel load value |
| q | output | STAGES*4 | Current count |
| carry_n | output | 1 | Terminal-count carry of the whole chain, active low |

## Verification
The bench builds the chain with `STAGES = 2`, which gives an 8-bit count. With this width a full sweep of all 256 states in each direction fits easily in the run. Both wrap points and the carry between the two slices, in both directions, are reached. Carry between slices is the behaviour that the single-slice case could never show. The carry output is compared against an independent model on every cycle, and mid-cycle control changes are checked against the held count.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the up/down counter slices.
// Assumes slices are at least one bit wide; all arithmetic wraps modulo 2**width.
package updn_pkg;

    // Operation selected for a slice at the coming clock edge.
    typedef enum logic [2:0] {
        MODE_CLEAR = 3'd0,
        MODE_LOAD  = 3'd1,
        MODE_HOLD  = 3'd2,
        MODE_INC   = 3'd3,
        MODE_DEC   = 3'd4
    } slice_mode_e;

    // Default slice width of one counter stage.
    localparam int SLICE_W_DEF = 4;

endpackage

// File: rtl/updn_mode_dec.sv
`timescale 1ns/1ps
// Module: updn_mode_dec
// Decodes the active-low controls of one slice into a single operation.
// Priority: reset, then load, then count (both enables low), else hold.
// Assumes all inputs are stable around the clock edge; purely combinational.
module updn_mode_dec
    import updn_pkg::*;
(
    input  logic        rst_n,
    input  logic        load_n,
    input  logic        enp_n,
    input  logic        ent_n,
    input  logic        up_dn,
    output slice_mode_e mode
);

    // Select the slice operation by fixed priority.
    always_comb begin
        if (!rst_n) begin
            mode = MODE_CLEAR;
        end else if (!load_n) begin
            mode = MODE_LOAD;
        end else if (!enp_n && !ent_n) begin
            mode = up_dn ? MODE_INC : MODE_DEC;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/updn_term_det.sv
`timescale 1ns/1ps
// Module: updn_term_det
// Flags the terminal value of one slice in the selected direction and
// produces the active-low carry, gated by the slice's chain enable.
// Assumes the count input comes straight from the slice register.
module updn_term_det #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             up_dn,
    input  logic             ent_n,
    output logic             rco_n
);

    localparam logic [WIDTH-1:0] TOP_VAL = '1;
    localparam logic [WIDTH-1:0] BOT_VAL = '0;

    logic at_term;

    // Compare the count with the end value of the current direction.
    always_comb begin
        at_term = up_dn ? (cnt == TOP_VAL) : (cnt == BOT_VAL);
    end

    // Drive the carry low only while enabled and at the end value.
    always_comb begin
        rco_n = ~(~ent_n & at_term);
    end

endmodule

// File: rtl/updn_slice.sv
`timescale 1ns/1ps
// Module: updn_slice
// One synchronous up/down counter stage with parallel load, two active-low
// enables and an active-low terminal carry. All bits update together on the
// rising clock edge. Assumes a synchronous active-low reset.
module updn_slice
    import updn_pkg::*;
#(
    parameter int WIDTH = SLICE_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             enp_n,
    input  logic             ent_n,
    input  logic             up_dn,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             rco_n
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    slice_mode_e      mode;
    logic [WIDTH-1:0] cnt_r;

    updn_mode_dec u_dec (
        .rst_n  (rst_n),
        .load_n (load_n),
        .enp_n  (enp_n),
        .ent_n  (ent_n),
        .up_dn  (up_dn),
        .mode   (mode)
    );

    // Update the stage register according to the decoded operation.
    always_ff @(posedge clk) begin
        case (mode)
            MODE_CLEAR: cnt_r <= '0;
            MODE_LOAD:  cnt_r <= din;
            MODE_INC:   cnt_r <= cnt_r + ONE;
            MODE_DEC:   cnt_r <= cnt_r - ONE;
            default:    cnt_r <= cnt_r;
        endcase
    end

    updn_term_det #(.WIDTH(WIDTH)) u_term (
        .cnt   (cnt_r),
        .up_dn (up_dn),
        .ent_n (ent_n),
        .rco_n (rco_n)
    );

    // Expose the stage register.
    assign q = cnt_r;

endmodule

// File: rtl/updn_chain.sv
`timescale 1ns/1ps
// Module: updn_chain (top)
// Chains STAGES counter slices into one wide synchronous up/down counter.
// Each slice's carry drives the next slice's chain enable; load, direction
// and the shared count enable reach every slice. Assumes a synchronous
// active-low reset and a single clock.
module updn_chain #(
    parameter int STAGES  = 2,
    parameter int SLICE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_n,
    input  logic                      cnt_en_n,
    input  logic                      chain_en_n,
    input  logic                      up_dn,
    input  logic [STAGES*SLICE_W-1:0] din,
    output logic [STAGES*SLICE_W-1:0] q,
    output logic                      carry_n
);

    logic [STAGES:0] link_n;

    // The external chain enable feeds the lowest slice.
    assign link_n[0] = chain_en_n;

    for (genvar s = 0; s < STAGES; s++) begin : g_slice
        updn_slice #(.WIDTH(SLICE_W)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (load_n),
            .enp_n  (cnt_en_n),
            .ent_n  (link_n[s]),
            .up_dn  (up_dn),
            .din    (din[s*SLICE_W +: SLICE_W]),
            .q      (q[s*SLICE_W +: SLICE_W]),
            .rco_n  (link_n[s+1])
        );
    end

    // The top slice's carry is the carry of the whole chain.
    assign carry_n = link_n[STAGES];

endmodule

// File: rtl/updn_chain_chk.sv
`timescale 1ns/1ps
// Module: updn_chain_chk
// Property checker for updn_chain, bound to every instance of the top.
module updn_chain_chk #(
    parameter int STAGES  = 2,
    parameter int SLICE_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      load_n,
    input logic                      cnt_en_n,
    input logic                      chain_en_n,
    input logic                      up_dn,
    input logic [STAGES*SLICE_W-1:0] din,
    input logic [STAGES*SLICE_W-1:0] q,
    input logic                      carry_n
);

    localparam int W = STAGES * SLICE_W;
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] ALL1 = '1;

    // R2: a load copies the data input regardless of enables.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> q == $past(din));

    // R3: either enable high holds the count.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (cnt_en_n || chain_en_n)) |=> $stable(q));

    // R4: counting up adds one with wrap.
    p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && up_dn) |=> q == $past(q) + ONE);

    // R5: counting down subtracts one with wrap.
    p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && !up_dn) |=> q == $past(q) - ONE);

    // R6: the chain carry marks the full-width terminal value.
    p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry_n == !(!chain_en_n && (up_dn ? (q == ALL1) : (q == '0))));

    // R7: upper bits stay put while the lowest slice is not at its end value.
    p_cross_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && up_dn && (q[SLICE_W-1:0] != '1))
        |=> q[W-1:SLICE_W] == $past(q[W-1:SLICE_W]));

endmodule

bind updn_chain updn_chain_chk #(.STAGES(STAGES), .SLICE_W(SLICE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .cnt_en_n   (cnt_en_n),
    .chain_en_n (chain_en_n),
    .up_dn      (up_dn),
    .din        (din),
    .q          (q),
    .carry_n    (carry_n)
);

// File: tb/updn_chain_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for updn_chain with two slices (8-bit count).
module updn_chain_tb;

    localparam int STAGES = 2;
    localparam int W = STAGES * 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic         chain_en_n = 1'b1;
    logic         up_dn = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         carry_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] m_q = '0;
    logic [W-1:0] exp_q[$];
    string        exp_tag[$];

    always #2 clk = ~clk;

    updn_chain #(.STAGES(STAGES), .SLICE_W(4)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .chain_en_n (chain_en_n),
        .up_dn      (up_dn),
        .din        (din),
        .q          (q),
        .carry_n    (carry_n)
    );

    function automatic logic model_carry(input logic [W-1:0] v, input logic ent, input logic up);
        return !(!ent && (up ? (v == '1) : (v == '0)));
    endfunction

    // Driver: apply one cycle of inputs, check the carry, push the expected count.
    task automatic step(input logic rst, input logic ld, input logic enp, input logic ent,
                        input logic up, input logic [W-1:0] d, input string tag);
        logic ec;
        @(negedge clk);
        rst_n = rst; load_n = ld; cnt_en_n = enp; chain_en_n = ent; up_dn = up; din = d;
        #0.5;
        ec = model_carry(m_q, ent, up);
        checks++;
        if (carry_n !== ec) begin
            errors++;
            $display("FAIL R6 carry_n actual %0b expected %0b (q model %h)", carry_n, ec, m_q);
        end
        if (!rst)                m_q = '0;
        else if (!ld)            m_q = d;
        else if (!enp && !ent)   m_q = up ? m_q + W'(1) : m_q - W'(1);
        exp_q.push_back(m_q);
        exp_tag.push_back(tag);
    endtask

    // R8: toggle controls mid-cycle, check q is untouched, restore a hold setting.
    task automatic midcycle_probe(input logic [W-1:0] d);
        @(negedge clk);
        load_n = 1'b0; cnt_en_n = 1'b0; chain_en_n = 1'b0; up_dn = ~up_dn; din = d;
        #0.5;
        checks++;
        if (q !== m_q) begin
            errors++;
            $display("FAIL R8 q actual %h expected %h", q, m_q);
        end
        load_n = 1'b1; cnt_en_n = 1'b1; chain_en_n = 1'b1;
        exp_q.push_back(m_q);
        exp_tag.push_back("R8");
    endtask

    // Monitor: after each rising edge pop and compare the expected count.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                checks++;
                if (q !== e) begin
                    errors++;
                    $display("FAIL %s q actual %h expected %h", t, q, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset clears even with load requested.
        step(0, 0, 0, 0, 1, 8'hA5, "R1");
        step(0, 1, 1, 1, 1, 8'h00, "R1");
        // R2: load with enables high, then with enables low and down.
        step(1, 0, 1, 1, 1, 8'h5A, "R2");
        step(1, 0, 0, 0, 0, 8'hC3, "R2");
        // R3: hold with each enable high.
        for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 1, 8'h00, "R3");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0, 8'h00, "R3");
        // R7: cross the slice boundary up.
        step(1, 0, 1, 1, 1, 8'h0D, "R2");
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 1, 8'h00, "R7");
        // R4: wrap at all ones; carry low at 0xFF.
        step(1, 0, 1, 1, 1, 8'hFE, "R2");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 8'h00, "R4");
        // R6: carry stays high at 0xFF when chain enable is high.
        step(1, 0, 1, 1, 1, 8'hFF, "R2");
        step(1, 1, 0, 1, 1, 8'h00, "R6");
        step(1, 1, 1, 0, 0, 8'h00, "R6");
        // R7: cross the slice boundary down.
        step(1, 0, 1, 1, 0, 8'h11, "R2");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 8'h00, "R7");
        // R5: wrap at zero.
        step(1, 0, 1, 1, 0, 8'h01, "R2");
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 8'h00, "R5");
        // R8: mid-cycle control changes.
        for (int i = 0; i < 4; i++) midcycle_probe(8'h3C ^ W'(i));
        // R4 / R5: full sweeps.
        step(0, 1, 1, 1, 1, 8'h00, "R1");
        for (int i = 0; i < 260; i++) step(1, 1, 0, 0, 1, 8'h00, "R4");
        for (int i = 0; i < 260; i++) step(1, 1, 0, 0, 0, 8'h00, "R5");
        // R1: reset mid-count.
        step(0, 1, 0, 0, 1, 8'h00, "R1");
        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule